// File: doc/BRIEF.md
# Serial Receive Channel with Character Status Queue

This block is one asynchronous serial receive channel. It watches the incoming line on every pulse of a sixteen-times oversampling enable, finds and checks start bits, and assembles eight data bits, least significant first. It then samples the stop bit. Each finished character is paired with its own framing-error flag and placed in a three-entry queue. One further character can wait in a holding register behind the queue. The CPU side sees the oldest character and a status byte at all times, and a one-cycle read strobe removes that character.

The channel reports three flags: a character is waiting, the queue is full, and a character was lost. It drives an active-low strobe, which can be enabled and can show either the waiting flag or the full flag. It also drives an active-low request-to-send line. Software sets and clears that line, and the receiver can withdraw it by itself when a new character begins while the queue is already full. Two single-cycle commands are provided. One flushes the channel back to its idle state. The other clears the lost-character flag. Baud generation, the transmitter and address decoding live outside the block.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset, `rx_status` is 0x00, `rts_n` is 1 and `rdy_strobe_n` is 1.
- R2: A frame is a low start bit, eight data bits least significant first, and a stop bit. The line idles high. Each bit is sampled near its centre on the sixteen-times enable. The oldest queued byte appears on `rx_data`.
- R3: A start bit is checked at the eighth enable pulse after the line is first seen low. If the line is high again at that point, no character is produced.
- R4: A character whose stop bit is sampled low is stored with a framing flag set. `rx_status` bit 6 shows that flag for the oldest queued character.
- R5: `rx_status` bit 0 is 1 while at least one character is queued. `rx_status` bit 1 is 1 while the queue holds three characters.
- R6: When the queue is full, a fourth character waits in the holding register. A read moves it into the queue, and characters always leave in arrival order.
- R7: If a character completes while the queue is full and the holding register is occupied, `rx_status` bit 4 (overrun) is set. The new character replaces the held one, and the three queued characters are kept. Overrun stays set until `cmd_reset_err` is pulsed.
- R8: A read strobe while nothing is queued has no effect.
- R9: `rdy_strobe_n` is 1 while `strobe_en` is 0. Otherwise it is low when the selected flag is 1: the full flag when `strobe_sel_full` is 1, the waiting flag when it is 0.
- R10: `rts_set` drives `rts_n` low and `rts_clr` drives it high. While `rts_auto_en` is 1, a validated start bit that arrives while the queue is full drives `rts_n` high. When `rts_auto_en` is 0, `rts_n` is left alone.
- R11: `cmd_reset_chan` empties the queue and the holding register, clears overrun, and returns the framer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sixteen-times bit-rate sample enable |
| rxd | input | 1 | Serial input line, idle high |
| rd_pop | input | 1 | Removes the oldest character |
| cmd_reset_chan | input | 1 | Flushes the channel to idle |
| cmd_reset_err | input | 1 | Clears the overrun flag |
| rts_set | input | 1 | Drives request-to-send active |
| rts_clr | input | 1 | Drives request-to-send inactive |
| rts_auto_en | input | 1 | Enables automatic request-to-send withdrawal |
| strobe_en | input | 1 | Enables the ready strobe output |
| strobe_sel_full | input | 1 | Strobe shows full (1) or waiting (0) |
| rx_data | output | 8 | Oldest queued byte |
| rx_status | output | 8 | Bit0 waiting, bit1 full, bit4 overrun, bit6 framing error of oldest |
| rdy_strobe_n | output | 1 | Active-low ready or full strobe |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The hardest state to reach is an overrun. To get there, three characters must already sit in the queue, a fourth must be parked in the holding register, and a fifth must finish before any read. The bench therefore sends five whole frames with reads held off. It then reads out the queue and expects the first three bytes followed by the fifth, with the fourth gone. Automatic request-to-send withdrawal needs a similar setup: a start bit has to be validated while the queue is full. The bench sends a fourth frame only after three are queued and RTS has been driven active.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW = 8;

  typedef struct packed {
    logic              ferr;
    logic [SRX_DW-1:0] data;
  } srx_char_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } srx_state_e;
endpackage

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      tick,
  input  logic      rxd_in,
  output logic      start_ok,
  output logic      done,
  output srx_char_t chr
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(SRX_DW);
  localparam int MID = OSR / 2;

  logic [1:0]        sync_q;
  srx_state_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bi_q, bi_d;
  logic [SRX_DW-1:0] sh_q, sh_d;
  logic              rx_s;

  assign rx_s = sync_q[1];

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    bi_d     = bi_q;
    sh_d     = sh_q;
    start_ok = 1'b0;
    done     = 1'b0;
    if (flush) begin
      st_d = RX_IDLE;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: if (!rx_s) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
        RX_START: if (cnt_q == CW'(MID - 1)) begin
          cnt_d = '0;
          bi_d  = '0;
          if (!rx_s) begin
            st_d     = RX_DATA;
            start_ok = 1'b1;
          end else begin
            st_d = RX_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        RX_DATA: if (cnt_q == CW'(OSR - 1)) begin
          cnt_d = '0;
          sh_d  = {rx_s, sh_q[SRX_DW-1:1]};
          if (bi_q == BW'(SRX_DW - 1)) st_d = RX_STOP;
          else                         bi_d = bi_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: if (cnt_q == CW'(OSR - 1)) begin
          cnt_d = '0;
          done  = 1'b1;
          st_d  = RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign chr.data = sh_q;
  assign chr.ferr = !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bi_q   <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_in};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bi_q   <= bi_d;
      sh_q   <= sh_d;
    end
  end

  assert_start_before_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && st_d == RX_DATA) |-> !rx_s);
endmodule

// File: rtl/srx_hold_fifo.sv
module srx_hold_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  srx_char_t wdat,
  input  logic      pop,
  output srx_char_t head,
  output logic      nonempty,
  output logic      full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  srx_char_t     mem [DEPTH];
  logic [PW-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [NW-1:0] n_q, n_d;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (n_q != '0);
  assign full     = (n_q == NW'(DEPTH));
  assign head     = mem[rp_q];

  always_comb begin
    rp_d = rp_q;
    wp_d = wp_q;
    n_d  = n_q;
    if (flush) begin
      rp_d = '0;
      wp_d = '0;
      n_d  = '0;
    end else begin
      if (push) wp_d = wrap_inc(wp_q);
      if (pop)  rp_d = wrap_inc(rp_q);
      if (push && !pop)      n_d = n_q + 1'b1;
      else if (pop && !push) n_d = n_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && wp_q == PW'(g)) mem[g] <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q <= '0;
      wp_q <= '0;
      n_q  <= '0;
    end else begin
      rp_q <= rp_d;
      wp_q <= wp_d;
      n_q  <= n_d;
    end
  end

  assert_fifo_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  assert_fifo_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
  import srx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rd_pop,
  input  logic       cmd_reset_chan,
  input  logic       cmd_reset_err,
  input  logic       rts_set,
  input  logic       rts_clr,
  input  logic       rts_auto_en,
  input  logic       strobe_en,
  input  logic       strobe_sel_full,
  output logic [7:0] rx_data,
  output logic [7:0] rx_status,
  output logic       rdy_strobe_n,
  output logic       rts_n
);
  logic      start_ok, done, f_ready, f_full, pop_ok, f_push;
  srx_char_t chr, head, f_wdat, hold_q, hold_d;
  logic      hold_v_q, hold_v_d, ovr_q, ovr_d, rts_q, rts_d, ovr_set;

  srx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .flush(cmd_reset_chan), .tick(tick16),
    .rxd_in(rxd), .start_ok(start_ok), .done(done), .chr(chr)
  );

  srx_hold_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_reset_chan), .push(f_push),
    .wdat(f_wdat), .pop(pop_ok), .head(head), .nonempty(f_ready), .full(f_full)
  );

  assign pop_ok  = rd_pop && f_ready;
  assign f_push  = (pop_ok && hold_v_q) ||
                   (done && (!f_full || (pop_ok && !hold_v_q)));
  assign f_wdat  = (pop_ok && hold_v_q) ? hold_q : chr;
  assign ovr_set = done && f_full && hold_v_q && !pop_ok;

  always_comb begin
    hold_d   = hold_q;
    hold_v_d = hold_v_q;
    if (cmd_reset_chan) begin
      hold_v_d = 1'b0;
    end else if (pop_ok && hold_v_q) begin
      hold_v_d = done;
      if (done) hold_d = chr;
    end else if (done && f_full && !pop_ok) begin
      hold_v_d = 1'b1;
      hold_d   = chr;
    end
    ovr_d = (ovr_q && !cmd_reset_err && !cmd_reset_chan) ||
            (ovr_set && !cmd_reset_chan);
    rts_d = rts_q;
    if (rts_set) rts_d = 1'b0;
    if (rts_clr) rts_d = 1'b1;
    if (rts_auto_en && start_ok && f_full) rts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      ovr_q    <= 1'b0;
      rts_q    <= 1'b1;
    end else begin
      hold_q   <= hold_d;
      hold_v_q <= hold_v_d;
      ovr_q    <= ovr_d;
      rts_q    <= rts_d;
    end
  end

  assign rx_data      = head.data;
  assign rx_status    = {1'b0, head.ferr && f_ready, 1'b0, ovr_q, 2'b00, f_full, f_ready};
  assign rdy_strobe_n = !(strobe_en && (strobe_sel_full ? f_full : f_ready));
  assign rts_n        = rts_q;

  assert_hold_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v_q |-> f_full);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !cmd_reset_err && !cmd_reset_chan) |=> ovr_q);
  assert_full_implies_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    f_full |-> f_ready);
  assert_rts_auto_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && start_ok && f_full) |=> rts_n);
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_chan |=> (!f_ready && !ovr_q));
endmodule

// File: tb/serial_rx_channel_test.sv
`timescale 1ns/1ps
module serial_rx_channel_test;
  logic clk = 1'b0;
  logic rst_n, rxd, rd_pop, cmd_reset_chan, cmd_reset_err;
  logic rts_set, rts_clr, rts_auto_en, strobe_en, strobe_sel_full;
  logic [7:0] rx_data, rx_status;
  logic rdy_strobe_n, rts_n, tick16;
  logic [1:0] tdiv = 2'd0;
  int checks = 0, errors = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd0);

  serial_rx_channel uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rd_pop(rd_pop),
    .cmd_reset_chan(cmd_reset_chan), .cmd_reset_err(cmd_reset_err),
    .rts_set(rts_set), .rts_clr(rts_clr), .rts_auto_en(rts_auto_en),
    .strobe_en(strobe_en), .strobe_sel_full(strobe_sel_full),
    .rx_data(rx_data), .rx_status(rx_status), .rdy_strobe_n(rdy_strobe_n), .rts_n(rts_n)
  );

  // {bad stop, data}
  localparam logic [8:0] VEC [8] = '{9'h0A5, 9'h05A, 9'h000, 9'h0FF,
                                     9'h101, 9'h080, 9'h1C3, 9'h001};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic bad_stop);
    rxd = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (64) @(negedge clk);
    end
    if (bad_stop) begin
      rxd = 1'b0;
      repeat (48) @(negedge clk);
      rxd = 1'b1;
      repeat (16) @(negedge clk);
    end else begin
      rxd = 1'b1;
      repeat (64) @(negedge clk);
    end
    repeat (32) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d);
    chk(req, {8'h0, rx_data}, {8'h0, d});
    pulse(rd_pop);
  endtask

  initial begin
    #400000;
    if (!fin) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rd_pop = 1'b0; cmd_reset_chan = 1'b0; cmd_reset_err = 1'b0;
    rts_set = 1'b0; rts_clr = 1'b0; rts_auto_en = 1'b0; strobe_en = 1'b1; strobe_sel_full = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    // R1 reset state
    chk("R1 status", {8'h0, rx_status}, 16'h0);
    chk("R1 rts_n", {15'h0, rts_n}, 16'h1);
    chk("R1 strobe", {15'h0, rdy_strobe_n}, 16'h1);

    // R2 R4 table walk
    foreach (VEC[i]) begin
      send_char(VEC[i][7:0], VEC[i][8]);
      chk("R5 ready after one char", {14'h0, rx_status[1:0]}, 16'h1);
      chk("R4 framing flag", {15'h0, rx_status[6]}, {15'h0, VEC[i][8]});
      pop_expect("R2 data", VEC[i][7:0]);
      chk("R5 empty after pop", {8'h0, rx_status}, 16'h0);
    end

    // R3 short low pulse is not a start
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (120) @(negedge clk);
    chk("R3 glitch rejected", {8'h0, rx_status}, 16'h0);

    // R8 pop when empty, then normal reception
    pulse(rd_pop);
    chk("R8 empty pop", {8'h0, rx_status}, 16'h0);
    send_char(8'h3C, 1'b0);
    // R9 strobe select
    chk("R9 ready strobe", {15'h0, rdy_strobe_n}, 16'h0);
    strobe_sel_full = 1'b1; @(negedge clk);
    chk("R9 full strobe not full", {15'h0, rdy_strobe_n}, 16'h1);
    strobe_sel_full = 1'b0; strobe_en = 1'b0; @(negedge clk);
    chk("R9 strobe disabled", {15'h0, rdy_strobe_n}, 16'h1);
    strobe_en = 1'b1;
    pop_expect("R8 data after empty pop", 8'h3C);

    // R6 R7 fill queue, hold, overrun
    send_char(8'h11, 1'b0); send_char(8'h22, 1'b0); send_char(8'h33, 1'b0);
    chk("R5 full flags", {8'h0, rx_status}, 16'h03);
    strobe_sel_full = 1'b1; @(negedge clk);
    chk("R9 full strobe", {15'h0, rdy_strobe_n}, 16'h0);
    strobe_sel_full = 1'b0;
    send_char(8'h44, 1'b0);
    chk("R6 held, no overrun", {8'h0, rx_status}, 16'h03);
    send_char(8'h55, 1'b0);
    chk("R7 overrun set", {8'h0, rx_status}, 16'h13);
    pop_expect("R7 first kept", 8'h11);
    chk("R6 still full after hold moves in", {8'h0, rx_status}, 16'h13);
    pop_expect("R7 second kept", 8'h22);
    pop_expect("R7 third kept", 8'h33);
    pop_expect("R7 held overwritten", 8'h55);
    chk("R7 overrun sticky", {8'h0, rx_status}, 16'h10);
    pulse(cmd_reset_err);
    chk("R7 reset error", {8'h0, rx_status}, 16'h00);

    // R10 rts control
    pulse(rts_set);
    chk("R10 rts set", {15'h0, rts_n}, 16'h0);
    pulse(rts_clr);
    chk("R10 rts clear", {15'h0, rts_n}, 16'h1);
    pulse(rts_set);
    send_char(8'h61, 1'b0); send_char(8'h62, 1'b0); send_char(8'h63, 1'b0);
    send_char(8'h64, 1'b0);
    chk("R10 auto disabled keeps rts", {15'h0, rts_n}, 16'h0);
    // R11 flush
    pulse(cmd_reset_chan);
    chk("R11 flushed", {8'h0, rx_status}, 16'h00);
    rts_auto_en = 1'b1;
    send_char(8'h71, 1'b0); send_char(8'h72, 1'b0); send_char(8'h73, 1'b0);
    chk("R10 rts active before full start", {15'h0, rts_n}, 16'h0);
    send_char(8'h74, 1'b0);
    chk("R10 auto withdraw", {15'h0, rts_n}, 16'h1);
    pulse(cmd_reset_chan);
    send_char(8'h9E, 1'b0);
    pop_expect("R11 receive after flush", 8'h9E);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule